// File: doc/BRIEF.md
# FSK Phase-Slip Carrier Generator

This block turns a fixed system clock into a square-wave carrier. At the default clock of 4 MHz and 16 clocks per half-period, the carrier runs at 125 kHz. Data rides on the carrier as phase slips. Now and then a half-period is held for twice its normal length, so one toggle is skipped. The rate at which these slips repeat is the modulation. The two slip rhythms place energy in two pairs of sidebands around the carrier, and these sidebands form the FSK tones.

A controller places a transport frame on `frame_in` and pulses `start`. The block latches the frame and walks through it from the most significant bit down. Each bit picks one of two slip rhythms for one data cell. The whole frame is sent a fixed number of times back to back, and then the block stops. `busy` is high for the whole burst, and `done` pulses once when it ends. Between bursts the carrier output rests high.

Top module: `fsk_slip_gen`

## Requirements
- R1: After reset `rf_out` is 1, `busy` is 0 and `done` is 0, and `rf_out` stays 1 whenever `busy` is 0.
- R2: A normal half-period of `rf_out` lasts exactly HALF_CLKS clocks (16 by default, giving 125 kHz from 4 MHz).
- R3: A slip half-period lasts exactly 2*HALF_CLKS clocks before the next toggle.
- R4: A frame bit of 0 selects the short rhythm. Each group is SHORT_A (6) normal half-periods followed by one slip, and the cell is REPS_A (12) such groups.
- R5: A frame bit of 1 selects the long rhythm. Each group is SHORT_B (8) normal half-periods followed by one slip, and the cell is REPS_B (10) such groups.
- R6: The cells of a frame follow the frame bits from bit FRAME_BITS-1 down to bit 0, one cell per bit, and FRAME_BITS defaults to 96.
- R7: Each burst sends FRAME_COUNT (6) copies of the frame with no gap, so the next copy's first half-period follows the previous copy's last one directly.
- R8: When `start` is sampled high while `busy` is 0, `busy` is 1 from the next cycle. `rf_out` then holds 1 for the first half-period and makes its first toggle HALF_CLKS cycles after acceptance.
- R9: In the cycle after the final half-period of the last copy ends, `done` is 1 for exactly one cycle, `busy` is 0 and `rf_out` is 1.
- R10: `start` sampled while `busy` is 1 has no effect on `rf_out`, `busy` or `done`.
- R11: `frame_in` is captured when `start` is accepted, and changes to it during a burst do not alter the waveform.
- R12: While `busy` is 1, every half-period, including those at cell and frame boundaries, is exactly HALF_CLKS or 2*HALF_CLKS clocks long, with no short pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier time base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin one burst |
| frame_in | input | FRAME_BITS | Transport frame, sent from the top bit down |
| rf_out | output | 1 | Phase-slipped carrier, high at rest |
| busy | output | 1 | High while a burst is in progress |
| done | output | 1 | One-cycle pulse after the burst ends |

## Verification
Every result is due a fixed number of cycles after the edge that accepts `start`. `busy` rises at that edge, and the first toggle comes HALF_CLKS edges later. Each later toggle comes after the running sum of the half-period lengths that the bench computes from the frame bits. `done` appears one edge after the sum over all copies. The bench drives inputs and samples outputs on the falling clock edge. It walks this schedule one cycle at a time, comparing `rf_out`, `busy` and `done` at each sample against the level and flags the schedule predicts. Stray `start` pulses and frame changes injected mid-burst must therefore leave every sampled cycle unchanged, including a start in the final busy cycle.

// File: rtl/slip_pkg.sv
package slip_pkg;

   // bits needed to hold the values 0..n
   function automatic int unsigned cnt_width(input int unsigned n);
      int unsigned w;
      w = $clog2(n + 1);
      return (w < 1) ? 1 : w;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // rhythm selected by one transport bit
   typedef enum logic {
      RHY_SHORT = 1'b0,
      RHY_LONG  = 1'b1
   } rhythm_e;

endpackage

// File: rtl/fsk_half_timer.sv
module fsk_half_timer #(
   parameter int unsigned HALF_CLKS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   input  logic long_half,
   output logic half_end
);
   localparam int unsigned LONG_CLKS = 2 * HALF_CLKS;
   localparam int unsigned CW        = slip_pkg::cnt_width(LONG_CLKS);

   logic [CW-1:0] cnt;
   logic [CW-1:0] limit;

   assign limit    = long_half ? CW'(LONG_CLKS - 1) : CW'(HALF_CLKS - 1);
   assign half_end = run && (cnt == limit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart || half_end) begin
         cnt <= '0;
      end else if (run) begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/fsk_cadence_seq.sv
module fsk_cadence_seq #(
   parameter int unsigned SHORT_A = 6,
   parameter int unsigned SHORT_B = 8,
   parameter int unsigned REPS_A  = 12,
   parameter int unsigned REPS_B  = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  slip_pkg::rhythm_e sel,
   output logic             long_half,
   output logic             cell_end
);
   localparam int unsigned PW = slip_pkg::cnt_width(slip_pkg::max2(SHORT_A, SHORT_B));
   localparam int unsigned GW = slip_pkg::cnt_width(slip_pkg::max2(REPS_A, REPS_B));

   logic [PW-1:0] pos;
   logic [PW-1:0] last_pos;
   logic [GW-1:0] grp;
   logic [GW-1:0] last_grp;
   logic          grp_last;

   always_comb begin
      if (sel == slip_pkg::RHY_LONG) begin
         last_pos = PW'(SHORT_B);
         last_grp = GW'(REPS_B - 1);
      end else begin
         last_pos = PW'(SHORT_A);
         last_grp = GW'(REPS_A - 1);
      end
   end

   assign long_half = (pos == last_pos);
   assign grp_last  = (grp == last_grp);
   assign cell_end  = step && long_half && grp_last;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         pos <= '0;
         grp <= '0;
      end else if (step) begin
         if (long_half) begin
            pos <= '0;
            grp <= grp_last ? '0 : grp + 1'b1;
         end else begin
            pos <= pos + 1'b1;
         end
      end
   end
endmodule

// File: rtl/fsk_frame_ctrl.sv
module fsk_frame_ctrl #(
   parameter int unsigned FRAME_BITS  = 96,
   parameter int unsigned FRAME_COUNT = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [FRAME_BITS-1:0] frame_in,
   input  logic                  cell_end,
   output slip_pkg::rhythm_e     cur_rhythm,
   output logic                  burst_end
);
   localparam int unsigned BW = slip_pkg::cnt_width(FRAME_BITS - 1);

   logic [FRAME_BITS-1:0] shreg;
   logic [BW-1:0]         bit_idx;
   logic                  last_bit;
   logic                  last_frame;

   assign last_bit   = (bit_idx == BW'(FRAME_BITS - 1));
   assign cur_rhythm = slip_pkg::rhythm_e'(shreg[FRAME_BITS-1]);
   assign burst_end  = cell_end && last_bit && last_frame;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg   <= '0;
         bit_idx <= '0;
      end else if (load) begin
         shreg   <= frame_in;
         bit_idx <= '0;
      end else if (cell_end) begin
         // rotate so the frame is intact again for the next copy
         shreg   <= {shreg[FRAME_BITS-2:0], shreg[FRAME_BITS-1]};
         bit_idx <= last_bit ? '0 : bit_idx + 1'b1;
      end
   end

   generate
      if (FRAME_COUNT > 1) begin : g_multi
         localparam int unsigned FW = slip_pkg::cnt_width(FRAME_COUNT - 1);
         logic [FW-1:0] frm_idx;
         assign last_frame = (frm_idx == FW'(FRAME_COUNT - 1));
         always_ff @(posedge clk) begin
            if (!rst_n || load) begin
               frm_idx <= '0;
            end else if (cell_end && last_bit && !last_frame) begin
               frm_idx <= frm_idx + 1'b1;
            end
         end
      end else begin : g_single
         assign last_frame = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/fsk_slip_gen.sv
module fsk_slip_gen #(
   parameter int unsigned HALF_CLKS   = 16,
   parameter int unsigned SHORT_A     = 6,
   parameter int unsigned SHORT_B     = 8,
   parameter int unsigned REPS_A      = 12,
   parameter int unsigned REPS_B      = 10,
   parameter int unsigned FRAME_BITS  = 96,
   parameter int unsigned FRAME_COUNT = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [FRAME_BITS-1:0] frame_in,
   output logic                  rf_out,
   output logic                  busy,
   output logic                  done
);
   generate
      if (HALF_CLKS < 1) begin : g_bad_half
         $error("HALF_CLKS must be at least 1");
      end
      if (SHORT_A < 1 || SHORT_B < 1) begin : g_bad_short
         $error("each rhythm needs at least one normal half-period");
      end
      if (REPS_A < 1 || REPS_B < 1) begin : g_bad_reps
         $error("each cell needs at least one group");
      end
      if (FRAME_BITS < 2) begin : g_bad_bits
         $error("FRAME_BITS must be at least 2");
      end
      if (FRAME_COUNT < 1) begin : g_bad_count
         $error("FRAME_COUNT must be at least 1");
      end
   endgenerate

   logic              accept;
   logic              half_end;
   logic              long_half;
   logic              cell_end;
   logic              burst_end;
   slip_pkg::rhythm_e rhythm;

   assign accept = start && !busy;

   fsk_half_timer #(
      .HALF_CLKS(HALF_CLKS)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (accept),
      .run      (busy),
      .long_half(long_half),
      .half_end (half_end)
   );

   fsk_cadence_seq #(
      .SHORT_A(SHORT_A),
      .SHORT_B(SHORT_B),
      .REPS_A (REPS_A),
      .REPS_B (REPS_B)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (accept),
      .step     (half_end),
      .sel      (rhythm),
      .long_half(long_half),
      .cell_end (cell_end)
   );

   fsk_frame_ctrl #(
      .FRAME_BITS (FRAME_BITS),
      .FRAME_COUNT(FRAME_COUNT)
   ) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .frame_in  (frame_in),
      .cell_end  (cell_end),
      .cur_rhythm(rhythm),
      .burst_end (burst_end)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         rf_out <= 1'b1;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            busy   <= 1'b1;
            rf_out <= 1'b1;
         end else if (half_end) begin
            if (burst_end) begin
               busy   <= 1'b0;
               rf_out <= 1'b1;
               done   <= 1'b1;
            end else begin
               rf_out <= ~rf_out;
            end
         end
      end
   end
endmodule

// File: rtl/fsk_slip_gen_chk.sv
module fsk_slip_gen_chk #(
   parameter int unsigned HALF_CLKS = 16
) (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic rf_out,
   input logic busy,
   input logic done
);
   localparam int unsigned RW = slip_pkg::cnt_width(2 * HALF_CLKS + 1);

   logic          prev_rf;
   logic [RW-1:0] run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_rf <= 1'b1;
         run     <= '0;
      end else begin
         prev_rf <= rf_out;
         if (!busy) begin
            run <= '0;
         end else if (rf_out != prev_rf) begin
            run <= RW'(1);
         end else if (run != {RW{1'b1}}) begin
            run <= run + 1'b1;
         end
      end
   end

   // R1
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> rf_out);

   // R8
   start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && rf_out));

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R10
   busy_no_early_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R12
   half_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (rf_out != prev_rf)) |->
         ((run == RW'(HALF_CLKS)) || (run == RW'(2 * HALF_CLKS))));
endmodule

bind fsk_slip_gen fsk_slip_gen_chk #(
   .HALF_CLKS(HALF_CLKS)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .rf_out(rf_out),
   .busy  (busy),
   .done  (done)
);

// File: tb/tb_fsk_slip_gen.sv
module tb_fsk_slip_gen;
   localparam int unsigned H   = 2;
   localparam int unsigned SA  = 6;
   localparam int unsigned SB  = 8;
   localparam int unsigned RA  = 12;
   localparam int unsigned RB  = 10;
   localparam int unsigned FB  = 8;
   localparam int unsigned FC  = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start;
   logic [FB-1:0] frame_in;
   logic          rf_out;
   logic          busy;
   logic          done;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;

   fsk_slip_gen #(
      .HALF_CLKS(H), .SHORT_A(SA), .SHORT_B(SB), .REPS_A(RA), .REPS_B(RB),
      .FRAME_BITS(FB), .FRAME_COUNT(FC)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .frame_in(frame_in),
      .rf_out(rf_out), .busy(busy), .done(done)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // expected burst length in cycles, from the requirements
   function automatic int burst_len(input logic [FB-1:0] frm);
      int total = 0;
      for (int b = 0; b < int'(FB); b++) begin
         if (frm[b]) total += int'(RB * (SB * H + 2 * H));
         else        total += int'(RA * (SA * H + 2 * H));
      end
      return total * int'(FC);
   endfunction

   task automatic idle_check(input int cycles);
      for (int i = 0; i < cycles; i++) begin
         check(rf_out === 1'b1, "R1", "idle rf_out", rf_out, 1);
         check(busy === 1'b0, "R1", "idle busy", busy, 0);
         @(negedge clk);
      end
   endtask

   task automatic run_burst(input logic [FB-1:0] frm, input bit scramble,
                            input int inject_at);
      int    t;
      logic  level;
      bit    bv;
      int    reps;
      int    shorts;
      int    len;
      string tag;
      frame_in = frm;
      start    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (scramble) frame_in = ~frm ^ FB'($urandom);
      level = 1'b1;
      t     = 0;
      for (int f = 0; f < int'(FC); f++) begin
         for (int b = 0; b < int'(FB); b++) begin
            bv     = frm[int'(FB) - 1 - b];
            reps   = bv ? int'(RB) : int'(RA);
            shorts = bv ? int'(SB) : int'(SA);
            for (int g = 0; g < reps; g++) begin
               for (int p = 0; p <= shorts; p++) begin
                  len = (p == shorts) ? int'(2 * H) : int'(H);
                  if (scramble)                          tag = "R11";
                  else if (f > 0)                        tag = "R7";
                  else if (b == 0 && g == 0 && p == 0)   tag = "R8";
                  else if (b > 0 && g == 0 && p == 0)    tag = "R12";
                  else if (b == 0)                       tag = "R6";
                  else if (p == shorts)                  tag = "R3";
                  else if (b == 1)                       tag = "R2";
                  else if (bv)                           tag = "R5";
                  else                                   tag = "R4";
                  for (int c = 0; c < len; c++) begin
                     check(rf_out === level, tag, "rf_out level", rf_out, level);
                     check(busy === 1'b1, "R10", "busy during burst", busy, 1);
                     check(done === 1'b0, "R9", "done during burst", done, 0);
                     start = (t == inject_at);
                     t++;
                     @(negedge clk);
                  end
                  level = ~level;
               end
            end
         end
      end
      start = 1'b0;
      check(t == burst_len(frm), "R7", "schedule length", t, burst_len(frm));
      check(done === 1'b1, "R9", "done pulse", done, 1);
      check(busy === 1'b0, "R9", "busy after burst", busy, 0);
      check(rf_out === 1'b1, "R9", "rf_out after burst", rf_out, 1);
      @(negedge clk);
      check(done === 1'b0, "R9", "done width", done, 0);
      idle_check(3);
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL R9 watchdog: actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      int one_burst;
      void'($urandom(32'd20240611));
      rst_n    = 1'b0;
      start    = 1'b0;
      frame_in = '0;
      repeat (3) @(negedge clk);
      check(rf_out === 1'b1, "R1", "reset rf_out", rf_out, 1);
      check(busy === 1'b0, "R1", "reset busy", busy, 0);
      check(done === 1'b0, "R1", "reset done", done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      idle_check(4);

      // directed corners
      run_burst(8'h00, 1'b0, -1);                         // R4 only
      run_burst(8'hFF, 1'b0, 5);                          // R5, R10 early start
      run_burst(8'h80, 1'b0, -1);                         // R6 top bit first
      one_burst = burst_len(8'h01);
      run_burst(8'h01, 1'b0, one_burst - 1);              // R10 start in last busy cycle
      run_burst(8'hA5, 1'b1, one_burst / 2);              // R11 frame changed

      // random frames
      for (int k = 0; k < 4; k++) begin
         logic [FB-1:0] fr;
         fr = FB'($urandom);
         run_burst(fr, k[0], int'($urandom % 3000));
      end

      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule